// File: doc/BRIEF.md
# Rectangle Fill Engine

This block paints a solid, axis-aligned rectangle on a 240 by 320 pixel panel in a single 16-bit RGB565 colour (for instance 0xF800 is red, 0x07E0 green, 0x001F blue and 0xFFFF white). A command carries two corner coordinates and the colour through a valid/ready port. The block runs an accepted command to completion on a beat-level register bus master, whose beats are either index writes (select a controller register) or data writes (write the selected register or pixel memory).

For each command the block first programs the panel controller. It sets the address window in X and in Y, places the write cursor at the top-left corner, and selects the pixel memory port. It then issues one data beat of the colour for every pixel covered. Clearing the whole screen is a rectangle from (0,0) to (239,319). A command whose corners are reversed or lie off the panel is refused with a one-cycle error pulse, and no bus traffic is produced.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, cmdReady is 1, and busValid and errPulse are 0.
- R2: A command is taken in a cycle where cmdValid and cmdReady are both 1. From the cycle after it is taken, cmdReady stays 0 until the cycle after the last bus beat of that command has completed, and cmdReady is never 1 while busValid is 1.
- R3: The first two beats of an accepted command are an index beat of value 0x0044, then a data beat carrying x2[7:0] in bits 15:8 and x1[7:0] in bits 7:0.
- R4: Beats three to six are index 0x0045, data y1, index 0x0046, data y2, with the coordinates zero-extended to 16 bits.
- R5: Beats seven to ten are index 0x004E, data x1, index 0x004F, data y1 (X before Y).
- R6: Beat eleven is index 0x0022. It is followed by exactly (x2-x1+1)*(y2-y1+1) data beats, each carrying the command colour, with no index beat among them.
- R7: A rectangle covering the whole panel, (0,0) to (239,319), yields 76800 pixel data beats.
- R8: A command with x2<x1, y2<y1, x2>=240 or y2>=320 gives errPulse=1 in the cycle after acceptance, for one cycle only. It produces no bus beat, and cmdReady is 1 again in the following cycle.
- R9: A beat completes in a cycle where busValid and busReady are both 1. While busValid is 1 and busReady is 0, the next cycle keeps busValid at 1 and keeps busData and busIsIndex unchanged.
- R10: busIsIndex is 1 on index beats and 0 on data beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle and able to take a command |
| cmdX1 | input | 9 | Left column |
| cmdY1 | input | 9 | Top row |
| cmdX2 | input | 9 | Right column (inclusive) |
| cmdY2 | input | 9 | Bottom row (inclusive) |
| cmdColour | input | 16 | RGB565 fill colour |
| errPulse | output | 1 | One-cycle pulse for a refused command |
| busValid | output | 1 | Bus beat offered |
| busReady | input | 1 | Bus master takes the beat |
| busIsIndex | output | 1 | 1: index beat, 0: data beat |
| busData | output | 16 | Register number or data value |

## Verification
The step from the last setup beat into the pixel stream, and the step from the last pixel beat back to accepting a new command, can each fall in the same cycle as a bus stall release. The bench drives busReady from a pseudo-random pattern on alternate sweep commands, so completions land on every step of the setup sequence and on the final pixel. Every completed beat is compared with an arithmetic model of the beat list. A beat that is duplicated or lost at a boundary shows up as a count or order mismatch, and a change of data during a stall breaks the hold check.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  // Controller register numbers decoded by the panel controller
  localparam logic [7:0] REG_HWIN   = 8'h44;
  localparam logic [7:0] REG_VSTART = 8'h45;
  localparam logic [7:0] REG_VEND   = 8'h46;
  localparam logic [7:0] REG_CURX   = 8'h4E;
  localparam logic [7:0] REG_CURY   = 8'h4F;
  localparam logic [7:0] REG_PIXMEM = 8'h22;

  // Setup sequence: eleven beats, numbered 0..10
  localparam int SETUP_LAST = 10;
  localparam int STEP_W     = $clog2(SETUP_LAST + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STREAM,
    ST_REJECT
  } rfeState_t;

  typedef struct packed {
    logic load;       // capture command, restart step and pixel counts
    logic stepAdv;    // setup beat completed
    logic pixDec;     // pixel beat completed
    logic streaming;  // bus carries pixel data
  } rfeStrobe_t;

endpackage

// File: rtl/rfe_ctrl.sv
module rfe_ctrl
  import rfe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdOk,
  input  logic       lastStep,
  input  logic       lastPix,
  input  logic       busReady,
  output logic       cmdReady,
  output logic       busValid,
  output logic       errPulse,
  output rfeStrobe_t strb
);

  rfeState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strb     = '0;
    cmdReady = 1'b0;
    busValid = 1'b0;
    errPulse = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          if (cmdOk) begin
            strb.load = 1'b1;
            stateD    = ST_SETUP;
          end else begin
            stateD = ST_REJECT;
          end
        end
      end
      ST_SETUP: begin
        busValid = 1'b1;
        if (busReady) begin
          strb.stepAdv = 1'b1;
          if (lastStep) stateD = ST_STREAM;
        end
      end
      ST_STREAM: begin
        busValid       = 1'b1;
        strb.streaming = 1'b1;
        if (busReady) begin
          strb.pixDec = 1'b1;
          if (lastPix) stateD = ST_IDLE;
        end
      end
      ST_REJECT: begin
        errPulse = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rfe_datapath.sv
module rfe_datapath
  import rfe_pkg::*;
#(
  parameter int PANEL_W = 240,
  parameter int PANEL_H = 320,
  parameter int COORD_W = 9,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  rfeStrobe_t         strb,
  input  logic [COORD_W-1:0] cmdX1,
  input  logic [COORD_W-1:0] cmdY1,
  input  logic [COORD_W-1:0] cmdX2,
  input  logic [COORD_W-1:0] cmdY2,
  input  logic [DATA_W-1:0]  cmdColour,
  output logic               cmdOk,
  output logic               lastStep,
  output logic               lastPix,
  output logic               busIsIndex,
  output logic [DATA_W-1:0]  busData
);

  localparam int CNT_W = $clog2(PANEL_W * PANEL_H + 1);
  localparam logic [COORD_W-1:0] X_LIM = COORD_W'(PANEL_W);
  localparam logic [COORD_W-1:0] Y_LIM = COORD_W'(PANEL_H);

  logic [COORD_W-1:0] x1Q, y1Q, x2Q, y2Q;
  logic [DATA_W-1:0]  colourQ;
  logic [STEP_W-1:0]  stepQ;
  logic [CNT_W-1:0]   pixLeftQ;
  logic [CNT_W-1:0]   spanW, spanH, pixTotal;

  // Bounds check on the offered command
  assign cmdOk = (cmdX1 <= cmdX2) && (cmdY1 <= cmdY2) &&
                 (cmdX2 < X_LIM) && (cmdY2 < Y_LIM);

  // Covered pixel count, wide enough for a full panel
  assign spanW    = CNT_W'(cmdX2) - CNT_W'(cmdX1) + CNT_W'(1);
  assign spanH    = CNT_W'(cmdY2) - CNT_W'(cmdY1) + CNT_W'(1);
  assign pixTotal = spanW * spanH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      x1Q      <= '0;
      y1Q      <= '0;
      x2Q      <= '0;
      y2Q      <= '0;
      colourQ  <= '0;
      stepQ    <= '0;
      pixLeftQ <= '0;
    end else if (strb.load) begin
      x1Q      <= cmdX1;
      y1Q      <= cmdY1;
      x2Q      <= cmdX2;
      y2Q      <= cmdY2;
      colourQ  <= cmdColour;
      stepQ    <= '0;
      pixLeftQ <= pixTotal;
    end else begin
      if (strb.stepAdv) stepQ    <= stepQ + STEP_W'(1);
      if (strb.pixDec)  pixLeftQ <= pixLeftQ - CNT_W'(1);
    end
  end

  assign lastStep = (stepQ == STEP_W'(SETUP_LAST));
  assign lastPix  = (pixLeftQ == CNT_W'(1));

  // Beat selection: even steps are index beats, odd steps their data
  always_comb begin
    busIsIndex = 1'b0;
    busData    = colourQ;
    if (!strb.streaming) begin
      busIsIndex = ~stepQ[0];
      case (stepQ)
        STEP_W'(0):  busData = DATA_W'(REG_HWIN);
        STEP_W'(1):  busData = DATA_W'({x2Q[7:0], x1Q[7:0]});
        STEP_W'(2):  busData = DATA_W'(REG_VSTART);
        STEP_W'(3):  busData = DATA_W'(y1Q);
        STEP_W'(4):  busData = DATA_W'(REG_VEND);
        STEP_W'(5):  busData = DATA_W'(y2Q);
        STEP_W'(6):  busData = DATA_W'(REG_CURX);
        STEP_W'(7):  busData = DATA_W'(x1Q);
        STEP_W'(8):  busData = DATA_W'(REG_CURY);
        STEP_W'(9):  busData = DATA_W'(y1Q);
        default:     busData = DATA_W'(REG_PIXMEM);
      endcase
    end
  end

endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfe_pkg::*;
#(
  parameter int PANEL_W = 240,
  parameter int PANEL_H = 320,
  parameter int COORD_W = 9,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [COORD_W-1:0] cmdX1,
  input  logic [COORD_W-1:0] cmdY1,
  input  logic [COORD_W-1:0] cmdX2,
  input  logic [COORD_W-1:0] cmdY2,
  input  logic [DATA_W-1:0]  cmdColour,
  output logic               errPulse,
  output logic               busValid,
  input  logic               busReady,
  output logic               busIsIndex,
  output logic [DATA_W-1:0]  busData
);

  rfeStrobe_t strb;
  logic cmdOk, lastStep, lastPix;

  rfe_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOk    (cmdOk),
    .lastStep (lastStep),
    .lastPix  (lastPix),
    .busReady (busReady),
    .cmdReady (cmdReady),
    .busValid (busValid),
    .errPulse (errPulse),
    .strb     (strb)
  );

  rfe_datapath #(
    .PANEL_W (PANEL_W),
    .PANEL_H (PANEL_H),
    .COORD_W (COORD_W),
    .DATA_W  (DATA_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdX1      (cmdX1),
    .cmdY1      (cmdY1),
    .cmdX2      (cmdX2),
    .cmdY2      (cmdY2),
    .cmdColour  (cmdColour),
    .cmdOk      (cmdOk),
    .lastStep   (lastStep),
    .lastPix    (lastPix),
    .busIsIndex (busIsIndex),
    .busData    (busData)
  );

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int PANEL_W = 240,
  parameter int PANEL_H = 320,
  parameter int COORD_W = 9,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [COORD_W-1:0] cmdX1,
  input logic [COORD_W-1:0] cmdY1,
  input logic [COORD_W-1:0] cmdX2,
  input logic [COORD_W-1:0] cmdY2,
  input logic               errPulse,
  input logic               busValid,
  input logic               busReady,
  input logic               busIsIndex,
  input logic [DATA_W-1:0]  busData
);

  localparam logic [COORD_W-1:0] X_END = COORD_W'(PANEL_W);
  localparam logic [COORD_W-1:0] Y_END = COORD_W'(PANEL_H);

  logic taken, inBounds;
  assign taken    = cmdValid && cmdReady;
  assign inBounds = !(cmdX2 < cmdX1) && !(cmdY2 < cmdY1) &&
                    (cmdX2 < X_END) && (cmdY2 < Y_END);

  AST_NO_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !cmdReady); // R2

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busData) && $stable(busIsIndex)); // R9

  AST_FIRST_BEAT_HWIN: assert property (@(posedge clk) disable iff (!rstN)
    taken && inBounds |=> busValid && busIsIndex && (busData == DATA_W'(16'h0044))); // R3

  AST_BAD_CMD_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    taken && !inBounds |=> errPulse && !busValid); // R8

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse && cmdReady); // R8

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !busValid); // R8

endmodule

bind rect_fill_engine rfe_checker #(
  .PANEL_W (PANEL_W),
  .PANEL_H (PANEL_H),
  .COORD_W (COORD_W),
  .DATA_W  (DATA_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdReady   (cmdReady),
  .cmdX1      (cmdX1),
  .cmdY1      (cmdY1),
  .cmdX2      (cmdX2),
  .cmdY2      (cmdY2),
  .errPulse   (errPulse),
  .busValid   (busValid),
  .busReady   (busReady),
  .busIsIndex (busIsIndex),
  .busData    (busData)
);

// File: tb/sim_rect_fill_engine.sv
`timescale 1ns/1ps
module sim_rect_fill_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [8:0]  cmdX1 = '0, cmdY1 = '0, cmdX2 = '0, cmdY2 = '0;
  logic [15:0] cmdColour = '0;
  logic        errPulse, busValid, busIsIndex;
  logic        busReady = 1'b1;
  logic [15:0] busData;

  int checks = 0;
  int errors = 0;

  // expected command and monitor tallies
  int eX1, eY1, eX2, eY2, eCol;
  int beatCnt, hErr, vErr, cErr, pErr, idxErr, rdyErr, stabErr, errBeat;
  bit stallEn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit prevHold = 1'b0;
  logic [15:0] prevData;
  logic prevIdx;

  always #4 clk = ~clk;

  rect_fill_engine u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdX1(cmdX1), .cmdY1(cmdY1), .cmdX2(cmdX2), .cmdY2(cmdY2),
    .cmdColour(cmdColour), .errPulse(errPulse), .busValid(busValid),
    .busReady(busReady), .busIsIndex(busIsIndex), .busData(busData)
  );

  function automatic logic expIdx(int k);
    return (k <= 10) && (k % 2 == 0);
  endfunction

  function automatic logic [15:0] expData(int k);
    case (k)
      0:  return 16'h0044;
      1:  return {eX2[7:0], eX1[7:0]};
      2:  return 16'h0045;
      3:  return 16'(eY1);
      4:  return 16'h0046;
      5:  return 16'(eY2);
      6:  return 16'h004E;
      7:  return 16'(eX1);
      8:  return 16'h004F;
      9:  return 16'(eY1);
      10: return 16'h0022;
      default: return 16'(eCol);
    endcase
  endfunction

  // bus master model and beat monitor
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    busReady = stallEn ? lfsr[0] : 1'b1;
    #1;
    if (rstN) begin
      if (prevHold && (!busValid || busData !== prevData || busIsIndex !== prevIdx))
        stabErr++;
      prevHold = busValid && !busReady;
      prevData = busData;
      prevIdx  = busIsIndex;
      if (busValid && cmdReady) rdyErr++;
      if (busValid && errPulse) errBeat++;
      if (busValid && busReady) begin
        if (busIsIndex !== expIdx(beatCnt)) idxErr++;
        if (busData !== expData(beatCnt)) begin
          if (beatCnt <= 1)      hErr++;
          else if (beatCnt <= 5) vErr++;
          else if (beatCnt <= 9) cErr++;
          else                   pErr++;
        end
        beatCnt++;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCmd(int x1, int y1, int x2, int y2, int col, bit stall);
    bit bad;
    int n, guard;
    bad = (x2 < x1) || (y2 < y1) || (x2 >= 240) || (y2 >= 320);
    n = bad ? 0 : (x2 - x1 + 1) * (y2 - y1 + 1);
    @(negedge clk); #2;
    eX1 = x1; eY1 = y1; eX2 = x2; eY2 = y2; eCol = col;
    beatCnt = 0; hErr = 0; vErr = 0; cErr = 0; pErr = 0; idxErr = 0;
    rdyErr = 0; stabErr = 0; errBeat = 0;
    stallEn = stall;
    cmdX1 = 9'(x1); cmdY1 = 9'(y1); cmdX2 = 9'(x2); cmdY2 = 9'(y2);
    cmdColour = 16'(col);
    cmdValid = 1'b1;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    cmdX1 = 9'h1A5; cmdY1 = 9'h0F0; cmdColour = ~cmdColour;  // ignored while busy
    @(negedge clk); #2;
    if (bad) begin
      check(errPulse == 1'b1, "R8 errPulse after bad command", int'(errPulse), 1);
      check(busValid == 1'b0, "R8 no beat on bad command", int'(busValid), 0);
      @(negedge clk); #2;
      check(errPulse == 1'b0, "R8 errPulse single cycle", int'(errPulse), 0);
      check(cmdReady == 1'b1, "R8 ready after reject", int'(cmdReady), 1);
      check(beatCnt == 0, "R8 beat count on reject", beatCnt, 0);
    end else begin
      check(cmdReady == 1'b0, "R2 ready low after accept", int'(cmdReady), 0);
      guard = 0;
      while (!cmdReady && guard < 170000) begin
        @(negedge clk); #2;
        guard++;
      end
      check(beatCnt == n + 11, "R6 total beat count", beatCnt, n + 11);
      check(hErr == 0, "R3 horizontal window beats", hErr, 0);
      check(vErr == 0, "R4 vertical window beats", vErr, 0);
      check(cErr == 0, "R5 cursor beats", cErr, 0);
      check(pErr == 0, "R6 pixel index and colour beats", pErr, 0);
      check(idxErr == 0, "R10 index flag", idxErr, 0);
      check(rdyErr == 0, "R2 ready high during beats", rdyErr, 0);
      check(stabErr == 0, "R9 hold during stall", stabErr, 0);
      check(errBeat == 0, "R8 no error on good command", errBeat, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(cmdReady == 1'b1, "R1 reset ready", int'(cmdReady), 1);
    check(busValid == 1'b0, "R1 reset busValid", int'(busValid), 0);
    check(errPulse == 1'b0, "R1 reset errPulse", int'(errPulse), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // near-exhaustive sweep of small rectangles, stalls on alternate runs
    for (int x1 = 0; x1 < 4; x1++)
      for (int w = 1; w <= 3; w++)
        for (int yb = 0; yb < 2; yb++)
          for (int h = 1; h <= 2; h++) begin
            int y1 = (yb == 0) ? 0 : 317;
            runCmd(x1, y1, x1 + w - 1, y1 + h - 1,
                   (x1 * 16'h0841) ^ (w * 16'h1003) ^ (h << 11), (x1 + w + h) % 2 == 1);
          end

    // panel edges and named colours
    runCmd(239, 319, 239, 319, 16'hF800, 1'b1);
    runCmd(239, 300, 239, 319, 16'h07E0, 1'b1);
    runCmd(230, 319, 239, 319, 16'h001F, 1'b0);
    runCmd(100, 50, 131, 57, 16'hFFFF, 1'b1);

    // refused commands
    runCmd(5, 0, 4, 0, 16'h1234, 1'b0);
    runCmd(0, 9, 0, 8, 16'h1234, 1'b0);
    runCmd(0, 0, 240, 0, 16'h1234, 1'b0);
    runCmd(0, 0, 0, 320, 16'h1234, 1'b0);

    // full-panel clear: R7
    runCmd(0, 0, 239, 319, 16'h0000, 1'b0);
    check(beatCnt - 11 == 76800, "R7 full clear pixel beats", beatCnt - 11, 76800);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule